// File: doc/BRIEF.md
# Dual 8-bit Cascadable Interval Timer

This block keeps two 8-bit counters that run in one system clock domain. Each slow clock reaches the block as a one-cycle enable pulse. The first counter advances on each pulse of the auxiliary clock. It produces a display frame pulse at one of four division ratios.

The second counter is a programmable divider. It runs from one of three sources:
- the auxiliary pulse,
- the system sub-clock pulse,
- the carry of the first counter, which joins the two counters into a 16-bit chain.

The second counter raises a sticky interval flag at a selectable power-of-two rate. An enable bit gates that flag onto the interrupt request.

Software writes an 8-bit control byte, both counters, the enable bit and the flag, and can read all of them back. A single-bit hold in the control byte freezes the second counter. It also freezes the first counter when the chain source is selected.

Top module: `dual_itimer`

## Requirements
- R1: After reset the control byte, both counters, the enable bit, the flag, the frame pulse and the interrupt request are all 0.
- R2: The first counter adds one, modulo 256, for each cycle with `aux_tick` high, unless that counter is frozen by R6.
- R3: With frame code f = ctl[4:3] (0..3), `frame_pulse` is high for one cycle on the edge where the first counter advances to a value whose low 5+f bits are zero. This gives one pulse per 32, 64, 128 or 256 auxiliary ticks.
- R4: The second counter's source is set by {ctl[7], ctl[5]}. Code 00 selects `aux_tick`, code 10 selects `sub_tick`, and codes 01 and 11 select the carry of the first counter. The carry is a cycle in which the first counter advances from 255. A pulse on an unselected source has no effect.
- R5: With interval code n = ctl[2:0], the flag is set on the edge where the second counter advances to a value whose low n+1 bits are zero. This gives one set per 2^(n+1) advances.
- R6: With ctl[6] = 1, the second counter holds its value. The first counter also holds when ctl[5] = 1, and keeps counting when ctl[5] = 0.
- R7: The flag stays set until software writes it. A flag write loads `wdata[0]`. A hardware set in the same cycle as a software write of 0 leaves the flag at 1.
- R8: `irq` is high exactly while both the flag and the enable bit are 1.
- R9: A write to either counter loads `wdata`. In that cycle the write wins over counting.
- R10: The control byte reads back as written. Its bit layout, from MSB to LSB, is select[7], hold[6], divide[5], frame[4:3], interval[2:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| aux_tick | input | 1 | One-cycle pulse per auxiliary clock period |
| sub_tick | input | 1 | One-cycle pulse per sub-clock period |
| wdata | input | 8 | Write data for all software writes |
| ctl_we | input | 1 | Load control byte |
| cnt1_we | input | 1 | Load first counter |
| cnt2_we | input | 1 | Load second counter |
| ien_we | input | 1 | Load enable bit from wdata[0] |
| flag_we | input | 1 | Load flag from wdata[0] |
| ctl_q | output | 8 | Control byte |
| cnt1_q | output | 8 | First counter |
| cnt2_q | output | 8 | Second counter |
| ien_q | output | 1 | Interrupt enable bit |
| flag_q | output | 1 | Interval flag |
| frame_pulse | output | 1 | Frame clock pulse |
| irq | output | 1 | Interrupt request |

## Verification
The frame divider is run at its shortest and longest codes, with one tick short of the period and with the full period. A wrong mask width shows up as an early or missing pulse.

The second counter is driven in turn from each source. Pulses on the unselected sources are mixed in to prove that they are ignored. A chain test steps the first counter across 255 so that only the carry moves the second counter.

The hold tests are run with both divide settings, which separates the freeze of one stage from the freeze of both. Collisions are also tested: a hardware set against a software clear, and a counter write against a tick.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int CW = 8;

    typedef enum logic [1:0] {
        SRC_AUX  = 2'd0,
        SRC_CASC = 2'd1,
        SRC_SUB  = 2'd2
    } src_e;

    // mask of the low (base+code) bits, saturating at CW bits
    function automatic logic [CW-1:0] low_mask(input int unsigned base, input logic [2:0] code);
        logic [CW:0] one_hot;
        one_hot = (CW+1)'(1) << (base + code);
        return CW'(one_hot - (CW+1)'(1));
    endfunction
endpackage

// File: rtl/itmr_stage.sv
module itmr_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic         wr,
    input  logic [W-1:0] wd,
    output logic [W-1:0] cnt_q,
    output logic         carry
);
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (wr)  cnt_q <= wd;
        else if (adv) cnt_q <= cnt_q + W'(1);
    end

    assign carry = adv & ~wr & (&cnt_q);

    // R2
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !wr) |=> cnt_q == W'($past(cnt_q) + W'(1)));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !wr) |=> $stable(cnt_q));
    // R9
    write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> cnt_q == $past(wd));
endmodule

// File: rtl/itmr_src_sel.sv
module itmr_src_sel
    import itmr_pkg::*;
(
    input  logic sel,
    input  logic div,
    input  logic aux_tick,
    input  logic sub_tick,
    input  logic carry1,
    output src_e src,
    output logic adv
);
    always_comb begin
        if (div)      src = SRC_CASC;
        else if (sel) src = SRC_SUB;
        else          src = SRC_AUX;
    end

    always_comb begin
        unique case (src)
            SRC_AUX:  adv = aux_tick;
            SRC_SUB:  adv = sub_tick;
            SRC_CASC: adv = carry1;
            default:  adv = 1'b0;
        endcase
    end
endmodule

// File: rtl/dual_itimer.sv
module dual_itimer
    import itmr_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         aux_tick,
    input  logic         sub_tick,
    input  logic [7:0]   wdata,
    input  logic         ctl_we,
    input  logic         cnt1_we,
    input  logic         cnt2_we,
    input  logic         ien_we,
    input  logic         flag_we,
    output logic [7:0]   ctl_q,
    output logic [7:0]   cnt1_q,
    output logic [7:0]   cnt2_q,
    output logic         ien_q,
    output logic         flag_q,
    output logic         frame_pulse,
    output logic         irq
);
    localparam int FRAME_BASE = 5;
    localparam int IVL_BASE   = 1;

    logic       f_sel, f_hold, f_div;
    logic [1:0] f_frame;
    logic [2:0] f_ivl;
    logic       adv1, adv2, src_adv, carry1;
    logic       frame_hit, ivl_hit;
    logic [CW-1:0] nxt1, nxt2;
    src_e       src;

    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= wdata;
    end

    assign f_sel   = ctl_q[7];
    assign f_hold  = ctl_q[6];
    assign f_div   = ctl_q[5];
    assign f_frame = ctl_q[4:3];
    assign f_ivl   = ctl_q[2:0];

    assign adv1 = aux_tick & ~(f_hold & f_div);

    itmr_stage #(.W(CW)) stage1_i (
        .clk(clk), .rst_n(rst_n), .adv(adv1), .wr(cnt1_we), .wd(wdata),
        .cnt_q(cnt1_q), .carry(carry1));

    itmr_src_sel src_i (
        .sel(f_sel), .div(f_div), .aux_tick(aux_tick), .sub_tick(sub_tick),
        .carry1(carry1), .src(src), .adv(src_adv));

    assign adv2 = src_adv & ~f_hold;

    logic carry2_unused;
    itmr_stage #(.W(CW)) stage2_i (
        .clk(clk), .rst_n(rst_n), .adv(adv2), .wr(cnt2_we), .wd(wdata),
        .cnt_q(cnt2_q), .carry(carry2_unused));

    assign nxt1 = cnt1_q + CW'(1);
    assign nxt2 = cnt2_q + CW'(1);
    assign frame_hit = adv1 & ~cnt1_we & ((nxt1 & low_mask(FRAME_BASE, {1'b0, f_frame})) == '0);
    assign ivl_hit   = adv2 & ~cnt2_we & ((nxt2 & low_mask(IVL_BASE, f_ivl)) == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_pulse <= 1'b0;
            flag_q      <= 1'b0;
            ien_q       <= 1'b0;
        end else begin
            frame_pulse <= frame_hit;
            if (ivl_hit)      flag_q <= 1'b1;
            else if (flag_we) flag_q <= wdata[0];
            if (ien_we)       ien_q  <= wdata[0];
        end
    end

    assign irq = flag_q & ien_q;

    // R6
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_hold && f_div && !cnt1_we) |=> $stable(cnt1_q));
    // R6
    second_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (f_hold && !cnt2_we) |=> $stable(cnt2_q));
    // R7
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !flag_we) |=> flag_q);
    // R7
    hw_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_hit |=> flag_q);
    // R3
    frame_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_pulse && f_frame != 2'd0 && !ctl_we && !cnt1_we) |=> !frame_pulse);
    // R8
    irq_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien_q && flag_q));
endmodule

// File: tb/dual_itimer_tb_top.sv
module dual_itimer_tb_top;
    localparam time PERIOD = 10ns;

    logic clk = 1'b0, rst_n = 1'b0;
    logic aux_tick = 0, sub_tick = 0;
    logic [7:0] wdata = 0;
    logic ctl_we = 0, cnt1_we = 0, cnt2_we = 0, ien_we = 0, flag_we = 0;
    logic [7:0] ctl_q, cnt1_q, cnt2_q;
    logic ien_q, flag_q, frame_pulse, irq;

    int checks = 0, errors = 0, pulses;
    bit done = 0;

    typedef struct { string tag; int exp; } exp_t;
    exp_t sb_q[$];

    always #(PERIOD/2) clk = ~clk;

    dual_itimer dut_i (.*);

    // driver side: push expectation
    task automatic expect_val(input string tag, input int exp);
        sb_q.push_back('{tag, exp});
    endtask

    // monitor side: pop and compare against observed value
    task automatic observe(input int act);
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (act != e.exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", e.tag, act, e.exp);
        end
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        expect_val(tag, exp);
        observe(act);
    endtask

    task automatic wr_reg(input int which, input logic [7:0] d);
        @(negedge clk);
        wdata = d;
        case (which)
            0: ctl_we = 1;
            1: cnt1_we = 1;
            2: cnt2_we = 1;
            3: ien_we = 1;
            default: flag_we = 1;
        endcase
        @(negedge clk);
        {ctl_we, cnt1_we, cnt2_we, ien_we, flag_we} = '0;
    endtask

    task automatic aux_n(input int n);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk); aux_tick = 1;
            @(negedge clk); aux_tick = 0;
            if (frame_pulse) pulses++;
        end
    endtask

    task automatic sub_n(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); sub_tick = 1;
            @(negedge clk); sub_tick = 0;
        end
    endtask

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ctl", ctl_q, 0); chk("R1 cnt1", cnt1_q, 0); chk("R1 cnt2", cnt2_q, 0);
        chk("R1 flag", flag_q, 0); chk("R1 irq", irq, 0); chk("R1 ien", ien_q, 0);
        rst_n = 1;
        @(negedge clk);

        // R10 readback
        wr_reg(0, 8'hA5); chk("R10 ctl readback", ctl_q, 8'hA5);

        // R2/R3 frame code 0: /32
        wr_reg(0, 8'h00); wr_reg(1, 0);
        aux_n(31); chk("R3 f0 31 ticks", pulses, 0);
        aux_n(33); chk("R3 f0 next 33 ticks", pulses, 2);
        chk("R2 cnt1 after 64", cnt1_q, 64);
        // R3 frame code 3: /256
        wr_reg(0, 8'h18); wr_reg(1, 0);
        aux_n(255); chk("R3 f3 255 ticks", pulses, 0);
        aux_n(1); chk("R3 f3 256th tick", pulses, 1);

        // R4 aux source feeds counter 2, sub ignored
        wr_reg(0, 8'h07); wr_reg(2, 0);
        aux_n(3); sub_n(2); chk("R4 aux src cnt2", cnt2_q, 3);
        // R4 sub source, aux ignored; R5 n=2 -> /8
        wr_reg(0, 8'h82); wr_reg(2, 0); wr_reg(4, 0);
        aux_n(4); chk("R4 sub src ignores aux", cnt2_q, 0);
        sub_n(7); chk("R5 n2 after 7", flag_q, 0);
        sub_n(1); chk("R5 n2 after 8", flag_q, 1);
        // R7 software clear
        wr_reg(4, 0); chk("R7 sw clear", flag_q, 0);
        wr_reg(4, 1); chk("R7 sw set", flag_q, 1);
        wr_reg(4, 0);

        // R4 cascade, R5 n=0 -> /2
        wr_reg(0, 8'h20); wr_reg(1, 254); wr_reg(2, 0);
        sub_n(2);
        aux_n(1); chk("R4 casc no carry", cnt2_q, 0);
        aux_n(1); chk("R4 casc carry", cnt2_q, 1);
        chk("R5 n0 odd", flag_q, 0);
        wr_reg(1, 255); aux_n(1);
        chk("R4 casc carry2", cnt2_q, 2); chk("R5 n0 even", flag_q, 1);
        wr_reg(4, 0);

        // R6 hold with divide 0: cnt1 runs, cnt2 frozen
        wr_reg(0, 8'h40); wr_reg(1, 10); wr_reg(2, 20);
        aux_n(3); chk("R6 hold d0 cnt1", cnt1_q, 13); chk("R6 hold d0 cnt2", cnt2_q, 20);
        // R6 hold with divide 1: both frozen
        wr_reg(0, 8'h60); wr_reg(1, 255);
        aux_n(3); chk("R6 hold d1 cnt1", cnt1_q, 255); chk("R6 hold d1 cnt2", cnt2_q, 20);

        // R7 hardware set wins over same-cycle clear
        wr_reg(0, 8'h80); wr_reg(2, 1);
        @(negedge clk); sub_tick = 1; flag_we = 1; wdata = 0;
        @(negedge clk); sub_tick = 0; flag_we = 0;
        chk("R7 hw wins", flag_q, 1);

        // R8 irq gating
        chk("R8 irq en0", irq, 0);
        wr_reg(3, 1); chk("R8 irq en1", irq, 1);
        wr_reg(4, 0); chk("R8 irq flag0", irq, 0);

        // R9 write beats tick
        wr_reg(0, 8'h00);
        @(negedge clk); aux_tick = 1; cnt1_we = 1; wdata = 8'h42;
        @(negedge clk); aux_tick = 0; cnt1_we = 0;
        chk("R9 write wins", cnt1_q, 8'h42);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule